// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to eight device request lines and presents one level-style interrupt request to a processor. Each request line is captured on its rising edge into a pending bit. A pending line that is not masked, and that outranks every line currently in service, drives the processor request output high. The output stays high until the processor acknowledges it.

When the processor pulses its acknowledge input, the controller picks the winning line. Line 0 has the highest priority. The controller then moves that line from pending to in-service and returns a vector byte for one clock. The vector is a programmable base, always a multiple of eight, plus the line index.

Software reaches four byte registers over a small write-strobe bus with combinational read data. Address 0 is the mask register and address 1 is the vector base. Address 2 shows the pending bits and is read-only. Address 3 shows the in-service bits; a write there clears the in-service bits whose data bits are 1.

Top module: `vpic_top`

## Requirements
- R1: After reset, `intr_o` and `vec_valid_o` are low, the mask (address 0) reads 0xFF, the base (address 1) reads 0x08, and both pending (address 2) and in-service (address 3) read 0x00.
- R2: A rising edge on request line i that is unmasked, with nothing in service, sets pending bit i. `intr_o` is high after the clock edge that samples the edge.
- R3: A masked line (mask bit i = 1) never raises `intr_o`. Its pending bit i is still set and reads back at address 2.
- R4: Once `intr_o` is high, it stays high until an acknowledge or a register write removes its cause. After the only pending line is acknowledged, `intr_o` goes low.
- R5: A rising edge on `inta_i` makes `vec_valid_o` high for exactly one clock, starting with the edge that samples it. `vec_o` then equals base + line index; with base 8, line 1 gives 9.
- R6: When several eligible lines are pending at acknowledge, the lowest-numbered one is served.
- R7: An acknowledge clears the served line's pending bit and sets its in-service bit (bit i of address 3).
- R8: While line k is in service, pending lines with index >= k do not raise `intr_o`. Lines with index < k still do.
- R9: Writing address 3 clears every in-service bit whose write-data bit is 1.
- R10: A write to address 1 keeps only bits 7:3. The base reads back with bits 2:0 at zero.
- R11: An acknowledge with no eligible line returns vector base + 7 and changes neither pending nor in-service bits.
- R12: A write to address 0 sets the mask, bit i for line i (1 = masked), and the value reads back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 8 | Device request lines, rising-edge captured |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Read data of the addressed register |
| intr_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | Acknowledge from the processor, rising-edge detected |
| vec_o | output | 8 | Vector byte of the last acknowledge |
| vec_valid_o | output | 1 | One-clock strobe marking a new vector |

## Verification
A request edge that is present before clock edge N shows as a pending bit and on `intr_o` right after edge N. An acknowledge held across edge M produces `vec_valid_o` and `vec_o` after edge M, and the strobe is gone after edge M+1. A register write takes effect at the edge that samples it, and read data is combinational.

The bench drives all inputs 5 ns after a rising edge and samples 5 ns after the edge that should produce the result. It never samples within an edge. The stimulus covers priority order, blocking by in-service lines, masking, a changed base and a spurious acknowledge.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    typedef enum logic [1:0] {
        REG_MASK  = 2'd0,
        REG_BASE  = 2'd1,
        REG_PEND  = 2'd2,
        REG_INSVC = 2'd3
    } vpic_reg_e;

endpackage

// File: rtl/vpic_rise_detect.sv
module vpic_rise_detect #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o
);

    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
        rise_o = sig_i & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/vpic_prio_enc.sv
module vpic_prio_enc #(
    parameter int N     = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top down so the lowest set index is the last one written.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = i[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int NUM_LINES  = 8,
    parameter int VEC_W      = 8,
    parameter int RESET_BASE = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_i,
    input  logic                 bus_we_i,
    input  logic [1:0]           bus_addr_i,
    input  logic [VEC_W-1:0]     bus_wdata_i,
    output logic [VEC_W-1:0]     bus_rdata_o,
    output logic                 intr_o,
    input  logic                 inta_i,
    output logic [VEC_W-1:0]     vec_o,
    output logic                 vec_valid_o
);

    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int BASE_W = VEC_W - IDX_W;
    localparam logic [VEC_W-1:0] RB = VEC_W'(RESET_BASE);

    typedef struct packed {
        logic [NUM_LINES-1:0] pend;
        logic [NUM_LINES-1:0] isr;
        logic [NUM_LINES-1:0] mask;
        logic [BASE_W-1:0]    base_hi;
        logic [VEC_W-1:0]     vec;
        logic                 vec_valid;
    } vpic_state_t;

    vpic_state_t st_d, st_q;

    logic [NUM_LINES-1:0] irq_rise;
    logic                 ack_rise;
    logic [NUM_LINES-1:0] allowed;
    logic [NUM_LINES-1:0] cand;
    logic                 cand_found;
    logic [IDX_W-1:0]     cand_idx;

    vpic_rise_detect #(.W(NUM_LINES)) i_irq_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (irq_i),
        .rise_o (irq_rise)
    );

    vpic_rise_detect #(.W(1)) i_ack_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (inta_i),
        .rise_o (ack_rise)
    );

    // Lines strictly above the highest-priority in-service line may interrupt.
    always_comb begin
        logic blocked;
        blocked = 1'b0;
        allowed = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (st_q.isr[i]) blocked = 1'b1;
            allowed[i] = !blocked;
        end
    end

    assign cand = st_q.pend & ~st_q.mask & allowed;

    vpic_prio_enc #(.N(NUM_LINES)) i_cand_enc (
        .req_i   (cand),
        .found_o (cand_found),
        .idx_o   (cand_idx)
    );

    always_comb begin
        st_d           = st_q;
        st_d.vec_valid = 1'b0;
        if (ack_rise) begin
            st_d.vec_valid = 1'b1;
            if (cand_found) begin
                st_d.pend[cand_idx] = 1'b0;
                st_d.isr[cand_idx]  = 1'b1;
                st_d.vec            = {st_q.base_hi, cand_idx};
            end else begin
                st_d.vec = {st_q.base_hi, {IDX_W{1'b1}}};
            end
        end
        st_d.pend = st_d.pend | irq_rise;
        if (bus_we_i) begin
            case (vpic_reg_e'(bus_addr_i))
                REG_MASK:  st_d.mask    = bus_wdata_i[NUM_LINES-1:0];
                REG_BASE:  st_d.base_hi = bus_wdata_i[VEC_W-1:IDX_W];
                REG_INSVC: st_d.isr     = st_d.isr & ~bus_wdata_i[NUM_LINES-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend      <= '0;
            st_q.isr       <= '0;
            st_q.mask      <= '1;
            st_q.base_hi   <= RB[VEC_W-1:IDX_W];
            st_q.vec       <= '0;
            st_q.vec_valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (vpic_reg_e'(bus_addr_i))
            REG_MASK:  bus_rdata_o = VEC_W'(st_q.mask);
            REG_BASE:  bus_rdata_o = {st_q.base_hi, {IDX_W{1'b0}}};
            REG_PEND:  bus_rdata_o = VEC_W'(st_q.pend);
            default:   bus_rdata_o = VEC_W'(st_q.isr);
        endcase
    end

    assign intr_o      = cand_found;
    assign vec_o       = st_q.vec;
    assign vec_valid_o = st_q.vec_valid;

    // R5: the vector strobe never lasts two clocks
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> !vec_valid_o);

    // R5: an acknowledge with a winner returns that winner's index next cycle
    p_vec_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rise && cand_found) |=> (vec_valid_o && vec_o[IDX_W-1:0] == $past(cand_idx)));

    // R3: the request output needs an unmasked pending line
    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        intr_o |-> |(st_q.pend & ~st_q.mask));

    // R4: the request holds without an acknowledge or a register write
    p_intr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_o && !ack_rise && !bus_we_i) |=> intr_o);

    // R6: the encoder's choice is the lowest set bit of the candidates
    p_lowest_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cand_found |-> ((cand & ~(cand - 1'b1)) == (NUM_LINES'(1) << cand_idx)));

    // R11: a spurious acknowledge returns the top index and leaves in-service alone
    p_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rise && !cand_found && !bus_we_i)
            |=> (vec_o[IDX_W-1:0] == {IDX_W{1'b1}} && $stable(st_q.isr)));

endmodule

// File: tb/test_vpic_top.sv
module test_vpic_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq = '0;
    logic       we = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       intr;
    logic       inta = 1'b0;
    logic [7:0] vec;
    logic       vec_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vpic_top i_vpic_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (irq),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .intr_o      (intr),
        .inta_i      (inta),
        .vec_o       (vec),
        .vec_valid_o (vec_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        step();
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse_irq(input logic [7:0] lines);
        irq = lines;
        step();
        irq = '0;
    endtask

    task automatic ack(input string req, input int exp_vec);
        inta = 1'b1;
        step();
        chk({req, " strobe"}, int'(vec_valid), 1);
        chk({req, " vector"}, int'(vec), exp_vec);
        inta = 1'b0;
        step();
        chk("R5 strobe single", int'(vec_valid), 0);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 intr", int'(intr), 0);
        chk("R1 strobe", int'(vec_valid), 0);
        rd(2'd0, d); chk("R1 mask", d, 8'hFF);
        rd(2'd1, d); chk("R1 base", d, 8'h08);
        rd(2'd2, d); chk("R1 pending", d, 0);
        rd(2'd3, d); chk("R1 insvc", d, 0);
    endtask

    task automatic t_mask_rw();
        logic [7:0] d;
        wr(2'd0, 8'hF0);
        rd(2'd0, d); chk("R12 mask readback", d, 8'hF0);
        wr(2'd0, 8'h00);
        rd(2'd0, d); chk("R12 mask clear", d, 8'h00);
    endtask

    task automatic t_basic();
        logic [7:0] d;
        pulse_irq(8'h02);
        chk("R2 intr raised", int'(intr), 1);
        rd(2'd2, d); chk("R2 pending", d, 8'h02);
        ack("R5 line1", 9);
        rd(2'd3, d); chk("R7 insvc set", d, 8'h02);
        rd(2'd2, d); chk("R7 pending cleared", d, 8'h00);
        chk("R4 intr dropped", int'(intr), 0);
        wr(2'd3, 8'h02);
        rd(2'd3, d); chk("R9 end of service", d, 8'h00);
    endtask

    task automatic t_hold();
        pulse_irq(8'h08);
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R4 intr held", int'(intr), 1);
        end
        ack("R5 line3", 11);
        chk("R4 intr after ack", int'(intr), 0);
        wr(2'd3, 8'h08);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        pulse_irq(8'h24);
        ack("R6 lowest wins", 10);
        rd(2'd3, d); chk("R7 insvc line2", d, 8'h04);
        rd(2'd2, d); chk("R7 pending line5", d, 8'h20);
        chk("R8 lower blocked", int'(intr), 0);
        pulse_irq(8'h01);
        chk("R8 higher passes", int'(intr), 1);
        ack("R8 nested line0", 8);
        rd(2'd3, d); chk("R7 nested insvc", d, 8'h05);
        wr(2'd3, 8'h01);
        chk("R8 still blocked by line2", int'(intr), 0);
        wr(2'd3, 8'h04);
        chk("R9 release line5", int'(intr), 1);
        ack("R6 line5", 13);
        wr(2'd3, 8'h20);
        rd(2'd3, d); chk("R9 all clear", d, 8'h00);
    endtask

    task automatic t_masked();
        logic [7:0] d;
        wr(2'd0, 8'h10);
        pulse_irq(8'h10);
        for (int i = 0; i < 3; i++) begin
            chk("R3 masked quiet", int'(intr), 0);
            step();
        end
        rd(2'd2, d); chk("R3 pending recorded", d, 8'h10);
        wr(2'd0, 8'h00);
        chk("R3 unmask raises", int'(intr), 1);
        ack("R5 line4", 12);
        wr(2'd3, 8'h10);
    endtask

    task automatic t_base();
        logic [7:0] d;
        wr(2'd1, 8'h45);
        rd(2'd1, d); chk("R10 base aligned", d, 8'h40);
        pulse_irq(8'h40);
        ack("R10 new base vector", 8'h46);
        wr(2'd3, 8'h40);
    endtask

    task automatic t_spurious();
        logic [7:0] d;
        ack("R11 spurious", 8'h47);
        rd(2'd3, d); chk("R11 insvc unchanged", d, 8'h00);
        rd(2'd2, d); chk("R11 pending unchanged", d, 8'h00);
        chk("R11 intr low", int'(intr), 0);
    endtask

    initial begin
        #15;
        rst_n = 1'b1;
        step();
        t_reset();
        t_mask_rw();
        t_basic();
        t_hold();
        t_priority();
        t_masked();
        t_base();
        t_spurious();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule